// File: doc/BRIEF.md
# Parity-Augmented Content-Addressable Memory with Priority Output

This block is a small associative store. Software-side logic writes data words into numbered rows. The block adds one even-parity bit to each word when it is written, and that bit is kept alongside the word. A lookup presents a key together with a search strobe. The key's own parity is formed, and the key plus its parity is compared against every row at once. Each row yields one hit flag.

Every row has its own enable input. A disabled row is kept out of the comparison entirely, which is the logical view of a row whose match circuitry is powered down. When several enabled rows hit, the flags pass through a priority encoder. The encoder returns the lowest-numbered hitting row and a valid flag. The hit vector, the encoded row number and the valid flag are all registered. They change only on the clock edge that samples a search strobe, and they hold until the next search.

Top module: `parity_cam`

## Requirements
- R1: After reset, `hit_vec`, `hit_row` and `hit_valid` are all zero, and every row holds data 0 with parity bit 0.
- R2: A write with `wr_en` high stores `wr_data` into row `wr_row` together with an even-parity bit equal to the XOR of the data bits. No port writes the parity bit directly.
- R3: When `srch_go` is sampled high, on that same clock edge `hit_vec[i]` becomes 1 exactly when row i is enabled and both its stored data and its stored parity equal `srch_key` and the key's XOR parity.
- R4: A row whose `row_en` bit is 0 at the search edge reports no hit, whatever it stores.
- R5: When several rows hit, `hit_row` gives the lowest-numbered hitting row.
- R6: `hit_valid` is 1 exactly when at least one bit of `hit_vec` is 1. When no row hits, `hit_row` is 0.
- R7: On edges where `srch_go` is low, `hit_vec`, `hit_row` and `hit_valid` keep their values, even when writes take place.
- R8: If a write and a search reach the same row on the same edge, the search compares against the row's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_row | input | 5 | Row number to write |
| wr_data | input | 16 | Data word to store |
| row_en | input | 32 | One enable per row; 0 removes the row from searches |
| srch_go | input | 1 | Search strobe |
| srch_key | input | 16 | Search key |
| hit_vec | output | 32 | Registered per-row hit flags |
| hit_row | output | 5 | Registered number of the lowest hitting row |
| hit_valid | output | 1 | Registered flag set when any row hits |

## Verification
The assertions assume that `row_en` is steady across the search edge. They also assume that `wr_row` always names an existing row, so that the stored parity of every row stays consistent with its data. The bench drives all inputs on the falling edge, keeps `wr_row` inside the row range, and changes enables only between searches. With these conditions met, the registered hit vector can be compared with a model built from the enables and words held at the moment of the strobe.

// File: rtl/cam_pkg.sv
package cam_pkg;
   function automatic logic even_par(input logic [63:0] v);
      return ^v;
   endfunction
endpackage

// File: rtl/cam_row_store.sv
module cam_row_store #(
   parameter int ROWS  = 32,
   parameter int WIDTH = 16,
   localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [AW-1:0]               wr_row,
   input  logic [WIDTH-1:0]            wr_data,
   output logic [ROWS-1:0][WIDTH-1:0]  st_data,
   output logic [ROWS-1:0]             st_par
);
   import cam_pkg::*;

   logic wr_par;
   assign wr_par = even_par(64'(wr_data));

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_data[r] <= '0;
            st_par[r]  <= 1'b0;
         end else if (wr_en && (wr_row == AW'(r))) begin
            st_data[r] <= wr_data;
            st_par[r]  <= wr_par;
         end
      end
   end
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
   parameter int ROWS  = 32,
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]            key,
   input  logic                        key_par,
   input  logic [ROWS-1:0][WIDTH-1:0]  st_data,
   input  logic [ROWS-1:0]             st_par,
   input  logic [ROWS-1:0]             row_en,
   output logic [ROWS-1:0]             match
);
   for (genvar r = 0; r < ROWS; r++) begin : g_cmp
      assign match[r] = row_en[r] && (st_par[r] == key_par) && (st_data[r] == key);
   end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
   parameter int ROWS      = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int AW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic [ROWS-1:0] req,
   output logic [AW-1:0]   idx,
   output logic            any
);
   assign any = |req;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = ROWS - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < ROWS; i++) begin
            if (req[i]) idx = AW'(i);
         end
      end
   end
endmodule

// File: rtl/parity_cam.sv
module parity_cam #(
   parameter int ROWS      = 32,
   parameter int WIDTH     = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int AW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_row,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [ROWS-1:0]  row_en,
   input  logic             srch_go,
   input  logic [WIDTH-1:0] srch_key,
   output logic [ROWS-1:0]  hit_vec,
   output logic [AW-1:0]    hit_row,
   output logic             hit_valid
);
   import cam_pkg::*;

   if (ROWS < 2 || ROWS > 1024) begin : g_bad_rows
      $error("parity_cam: ROWS must lie in 2..1024");
   end
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("parity_cam: WIDTH must lie in 1..64");
   end

   logic [ROWS-1:0][WIDTH-1:0] st_data;
   logic [ROWS-1:0]            st_par;
   logic [ROWS-1:0]            match;
   logic [AW-1:0]              enc_idx;
   logic                       enc_any;
   logic                       key_par;

   assign key_par = even_par(64'(srch_key));

   cam_row_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_data(wr_data), .st_data(st_data), .st_par(st_par)
   );

   cam_match_array #(.ROWS(ROWS), .WIDTH(WIDTH)) u_match (
      .key(srch_key), .key_par(key_par), .st_data(st_data),
      .st_par(st_par), .row_en(row_en), .match(match)
   );

   cam_prio_enc #(.ROWS(ROWS), .LOW_FIRST(LOW_FIRST)) u_enc (
      .req(match), .idx(enc_idx), .any(enc_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vec   <= '0;
         hit_row   <= '0;
         hit_valid <= 1'b0;
      end else if (srch_go) begin
         hit_vec   <= match;
         hit_row   <= enc_idx;
         hit_valid <= enc_any;
      end
   end
endmodule

// File: rtl/parity_cam_chk.sv
module parity_cam_chk #(
   parameter int ROWS      = 32,
   parameter int WIDTH     = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int AW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        srch_go,
   input logic [WIDTH-1:0]            srch_key,
   input logic [ROWS-1:0]             row_en,
   input logic [ROWS-1:0][WIDTH-1:0]  st_data,
   input logic [ROWS-1:0]             st_par,
   input logic [ROWS-1:0]             hit_vec,
   input logic [AW-1:0]               hit_row,
   input logic                        hit_valid
);
   // R2: stored parity always agrees with stored data; so equal data implies equal parity
   always @(posedge clk) begin
      if (rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            p_par_consistent_r2: assert (st_par[r] == ^st_data[r])
               else $error("row %0d parity inconsistent", r);
            p_data_eq_par_eq_r3: assert ((st_data[r] != srch_key) || (st_par[r] == ^srch_key))
               else $error("row %0d equal data but parity differs", r);
         end
      end
   end

   p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      srch_go |=> ((hit_vec & ~$past(row_en)) == '0));

   p_valid_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid == (hit_vec != '0));

   p_row_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> hit_vec[hit_row]);

   if (LOW_FIRST) begin : g_low_chk
      p_none_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
         hit_valid |-> ((hit_vec & ((ROWS'(1) << hit_row) - ROWS'(1))) == '0));
   end

   p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_go |=> ($stable(hit_vec) && $stable(hit_row) && $stable(hit_valid)));

   p_miss_row_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |-> (hit_row == '0));
endmodule

bind parity_cam parity_cam_chk #(.ROWS(ROWS), .WIDTH(WIDTH), .LOW_FIRST(LOW_FIRST)) u_chk (
   .clk(clk), .rst_n(rst_n), .srch_go(srch_go), .srch_key(srch_key),
   .row_en(row_en), .st_data(st_data), .st_par(st_par),
   .hit_vec(hit_vec), .hit_row(hit_row), .hit_valid(hit_valid)
);

// File: tb/parity_cam_test.sv
module parity_cam_test;
   localparam int ROWS  = 32;
   localparam int WIDTH = 16;
   localparam int AW    = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    wr_row = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic [ROWS-1:0]  row_en = '1;
   logic             srch_go = 1'b0;
   logic [WIDTH-1:0] srch_key = '0;
   logic [ROWS-1:0]  hit_vec;
   logic [AW-1:0]    hit_row;
   logic             hit_valid;

   int errors = 0;
   int checks = 0;
   logic [WIDTH-1:0] model [ROWS];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   parity_cam uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_data(wr_data), .row_en(row_en), .srch_go(srch_go),
      .srch_key(srch_key), .hit_vec(hit_vec), .hit_row(hit_row),
      .hit_valid(hit_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int row, input logic [WIDTH-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_row = AW'(row); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[row] = d;
   endtask

   // one search; results checked against model after the sampling edge
   task automatic srch_chk(input string req, input logic [WIDTH-1:0] k);
      logic [ROWS-1:0] ev;
      logic [AW-1:0]   er;
      ev = '0;
      for (int i = 0; i < ROWS; i++) if (row_en[i] && model[i] == k) ev[i] = 1'b1;
      er = '0;
      for (int i = ROWS - 1; i >= 0; i--) if (ev[i]) er = AW'(i);
      @(negedge clk);
      srch_go = 1'b1; srch_key = k;
      @(negedge clk);
      srch_go = 1'b0;
      chk({req, " vec"}, hit_vec, ev);
      chk({req, " row"}, 32'(hit_row), 32'(er));
      chk({req, " valid"}, 32'(hit_valid), 32'(ev != '0));
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < ROWS; i++) model[i] = '0;
      #12 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 vec", hit_vec, 32'h0);
      chk("R1 row", 32'(hit_row), 32'h0);
      chk("R1 valid", 32'(hit_valid), 32'h0);
      // R1 cleared rows all hold zero: key 0 hits every row
      srch_chk("R1 cleared", 16'h0000);
      // R2 R3 distinct words, each found alone
      for (int i = 0; i < ROWS; i++) wr(i, 16'(16'hA003 + i * 16'h0125));
      for (int i = 0; i < ROWS; i++) srch_chk("R3 single", model[i]);
      // R2 words differing in one bit and in parity must not cross-hit
      wr(9, 16'h00F0);
      srch_chk("R2 onebit", 16'h00F1);
      srch_chk("R2 exact", 16'h00F0);
      // R6 absent key
      srch_chk("R6 miss", 16'hFFFF);
      chk("R6 miss row", 32'(hit_row), 32'h0);
      // R5 duplicates
      wr(5, 16'h5A5A); wr(12, 16'h5A5A); wr(30, 16'h5A5A);
      srch_chk("R5 dup", 16'h5A5A);
      chk("R5 lowest", 32'(hit_row), 32'd5);
      // R4 disabled rows
      row_en[5] = 1'b0;
      srch_chk("R4 one off", 16'h5A5A);
      chk("R4 next", 32'(hit_row), 32'd12);
      row_en = '0;
      srch_chk("R4 all off", 16'h5A5A);
      row_en = '1;
      // R7 hold across idle cycles and writes
      srch_chk("R7 setup", 16'h5A5A);
      wr(0, 16'h5A5A);
      repeat (3) @(negedge clk);
      chk("R7 vec", hit_vec, (32'h1 << 5) | (32'h1 << 12) | (32'h1 << 30));
      chk("R7 row", 32'(hit_row), 32'd5);
      chk("R7 valid", 32'(hit_valid), 32'h1);
      // R8 same-edge write and search on row 3 sees old contents
      @(negedge clk);
      wr_en = 1'b1; wr_row = 5'd3; wr_data = 16'hBEEF;
      srch_go = 1'b1; srch_key = model[3];
      @(negedge clk);
      wr_en = 1'b0; srch_go = 1'b0;
      chk("R8 old vec", hit_vec, 32'h1 << 3);
      chk("R8 old row", 32'(hit_row), 32'd3);
      model[3] = 16'hBEEF;
      srch_chk("R8 new", 16'hBEEF);
      // R3 sweep of single-bit keys over a one-hot table
      for (int i = 0; i < WIDTH; i++) wr(i, 16'(1 << i));
      for (int i = 0; i < WIDTH; i++) srch_chk("R3 onehot", 16'(1 << i));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule